// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

A compact 32-bit processor core that runs a small load/store instruction subset over several clock cycles per instruction. The subset has word load, word store, register add and subtract, an unconditional jump, a multiply that leaves its product in a dedicated hold register, and a move of that hold register into a general register. A control state machine steps every instruction through fetch, decode and register read, execute or address calculation, memory access and writeback. Stores and jumps leave the sequence early. Each state raises only the strobes that its cycle needs.

Instruction storage and data storage are separate arrays inside the core. Both act on the falling clock edge, and all control and datapath registers update on the rising edge. This split lets a memory read that is issued during a cycle be captured by a register at the end of that same cycle. The opcode is classified when the instruction word leaves instruction storage, so the state machine sees only an instruction class. A separate ALU-control decoder resolves register-type operations from the function field. A test environment preloads both arrays directly. The core's strobes, program counter and write ports are visible so that its progress can be followed cycle by cycle.

Top module: `mc_core`

## Requirements
- R1: While reset is low and in the first cycle after it, the program counter reads 0 and the core is in fetch. Every general register reads zero until it is first written.
- R2: A fetch takes one cycle. In that cycle the instruction-register write strobe and the PC write strobe are high. In the following cycle the program counter equals the fetched address plus 4.
- R3: Load word (opcode 100011) takes 5 cycles. Its address is rs plus the sign-extended 16-bit immediate. The data read strobe is high in cycle 4. In cycle 5 the register write strobe is high, the write address is rt and the write data is the word stored at address bits [11:2] under the default depth. A negative offset wraps modulo 2^32.
- R4: Store word (opcode 101011) takes 4 cycles. In cycle 4 the data write strobe is high, the data address is rs plus the sign-extended immediate and the data is register rt. A later load from that address returns the stored word.
- R5: Register-type instructions have opcode 000000, with rs in bits [25:21], rt in [20:16], rd in [15:11] and the function code in [5:0]. Function 100000 (add) and function 100010 (subtract, rs minus rt) take 4 cycles. In cycle 4 they write the result to rd, and the result wraps modulo 2^32.
- R6: Function 011000 (multiply) takes 4 cycles and writes no general register. It places the low 32 bits of rs times rt in the hold register. That value stays unchanged through later non-multiply instructions, jumps included.
- R7: Function 010010 takes 4 cycles. In cycle 4 it writes the hold register's value to rd.
- R8: Jump (opcode 000010) takes 2 cycles and raises the PC write strobe in cycle 2. The next fetch address is bits [31:28] of the fetch address plus 4, followed by instruction bits [25:0], followed by 00.
- R9: Register 0 reads as zero, and a write addressed to it has no effect.
- R10: An opcode outside the subset takes 2 cycles and writes nothing. A register-type function code outside the subset takes 4 cycles and does not raise the register write strobe.
- R11: The register write, data read, data write and instruction-register write strobes are never high together. The decode, execute and address cycles raise no strobe, except the PC write of a jump. The program counter changes only in cycles where the PC write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; registers on the rising edge, memories on the falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pc_o | output | 32 | Program counter |
| ir_write_o | output | 1 | Instruction-register write strobe (fetch cycle) |
| pc_write_o | output | 1 | PC write strobe |
| mem_read_o | output | 1 | Data memory read strobe |
| mem_write_o | output | 1 | Data memory write strobe |
| reg_write_o | output | 1 | General register write strobe |
| rf_waddr_o | output | 5 | Register write address (rd or rt) |
| rf_wdata_o | output | 32 | Register write data (memory data or ALU result) |
| dm_addr_o | output | 32 | Data memory byte address |
| dm_wdata_o | output | 32 | Data memory write data |

## Verification
The hardest behaviour to reach is persistence of the hold register. To show it, the stimulus places a multiply, lets several other instructions and a taken jump pass, and then reads the product back with a move, both before and after the jump. Writes that must have no effect cannot be seen directly at the ports. A write to register 0 and a register-type instruction with an unknown function code are therefore each followed by a store of the affected register, so the stored word exposes the register's contents. A load with a negative offset from register zero forces the address to wrap to the top word of data storage, and a load of an address just written by a store checks the order of falling-edge write and read.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_MUL = 6'h18;
  localparam logic [5:0] FN_MFP = 6'h12;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_MEMRD,
    ST_MEMWR, ST_WBMEM, ST_EXEC, ST_WBALU
  } state_e;

  typedef enum logic [2:0] {
    OC_NONE, OC_LOAD, OC_STORE, OC_RTYPE, OC_JUMP
  } opclass_e;

  typedef enum logic [1:0] {AO_ADD, AO_SUB, AO_MUL, AO_PROD} alu_op_e;

  typedef enum logic [1:0] {SB_REG, SB_FOUR, SB_IMM} srcb_e;

  function automatic opclass_e classify(input logic [5:0] op);
    case (op)
      OP_LOAD:  return OC_LOAD;
      OP_STORE: return OC_STORE;
      OP_RTYPE: return OC_RTYPE;
      OP_JUMP:  return OC_JUMP;
      default:  return OC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          re_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  // falling-edge port: a write lands before a read of the same word later on
  always @(negedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [$clog2(NREG)-1:0] raddr1_i,
  input  logic [$clog2(NREG)-1:0] raddr2_i,
  output logic [DW-1:0]           rdata1_o,
  output logic [DW-1:0]           rdata2_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata1_o = (raddr1_i == '0) ? '0 : regs_q[raddr1_i];
  assign rdata2_o = (raddr2_i == '0) ? '0 : regs_q[raddr2_i];

endmodule

// File: rtl/mc_alu_ctl.sv
module mc_alu_ctl
  import mc_pkg::*;
(
  input  logic       en_i,
  input  logic [5:0] funct_i,
  output alu_op_e    alu_op_o,
  output logic       rd_wb_o,
  output logic       mul_o
);
  always_comb begin
    alu_op_o = AO_ADD;
    rd_wb_o  = 1'b0;
    mul_o    = 1'b0;
    if (en_i) begin
      case (funct_i)
        FN_ADD: begin alu_op_o = AO_ADD;  rd_wb_o = 1'b1; end
        FN_SUB: begin alu_op_o = AO_SUB;  rd_wb_o = 1'b1; end
        FN_MUL: begin alu_op_o = AO_MUL;  mul_o   = 1'b1; end
        FN_MFP: begin alu_op_o = AO_PROD; rd_wb_o = 1'b1; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  opclass_e opclass_i,
  input  logic     rd_wb_i,
  input  logic     mul_i,
  output logic     ir_write_o,
  output logic     pc_write_o,
  output logic     pc_jump_o,
  output logic     mem_read_o,
  output logic     mem_write_o,
  output logic     reg_write_o,
  output logic     reg_dst_o,
  output logic     mem_to_reg_o,
  output logic     alu_src_a_o,
  output srcb_e    alu_src_b_o,
  output logic     use_funct_o,
  output logic     prod_write_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    ir_write_o   = 1'b0;
    pc_write_o   = 1'b0;
    pc_jump_o    = 1'b0;
    mem_read_o   = 1'b0;
    mem_write_o  = 1'b0;
    reg_write_o  = 1'b0;
    reg_dst_o    = 1'b0;
    mem_to_reg_o = 1'b0;
    alu_src_a_o  = 1'b1;
    alu_src_b_o  = SB_REG;
    use_funct_o  = 1'b0;
    prod_write_o = 1'b0;
    case (state_q)
      ST_FETCH: begin
        ir_write_o  = 1'b1;
        pc_write_o  = 1'b1;
        alu_src_a_o = 1'b0;
        alu_src_b_o = SB_FOUR;
        state_d     = ST_DECODE;
      end
      ST_DECODE: begin
        case (opclass_i)
          OC_LOAD, OC_STORE: state_d = ST_ADDR;
          OC_RTYPE:          state_d = ST_EXEC;
          OC_JUMP: begin
            pc_write_o = 1'b1;
            pc_jump_o  = 1'b1;
            state_d    = ST_FETCH;
          end
          default:           state_d = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        alu_src_b_o = SB_IMM;
        state_d     = (opclass_i == OC_LOAD) ? ST_MEMRD : ST_MEMWR;
      end
      ST_MEMRD: begin
        mem_read_o = 1'b1;
        state_d    = ST_WBMEM;
      end
      ST_MEMWR: begin
        mem_write_o = 1'b1;
        state_d     = ST_FETCH;
      end
      ST_WBMEM: begin
        reg_write_o  = 1'b1;
        mem_to_reg_o = 1'b1;
        state_d      = ST_FETCH;
      end
      ST_EXEC: begin
        use_funct_o  = 1'b1;
        prod_write_o = mul_i;
        state_d      = ST_WBALU;
      end
      ST_WBALU: begin
        use_funct_o = 1'b1;
        reg_write_o = rd_wb_i;
        reg_dst_o   = 1'b1;
        state_d     = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IM_AW = 10,
  parameter int DM_AW = 10,
  parameter int NREG  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic [DW-1:0]           pc_o,
  output logic                    ir_write_o,
  output logic                    pc_write_o,
  output logic                    mem_read_o,
  output logic                    mem_write_o,
  output logic                    reg_write_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [DW-1:0]           rf_wdata_o,
  output logic [DW-1:0]           dm_addr_o,
  output logic [DW-1:0]           dm_wdata_o
);
  localparam int RAW   = $clog2(NREG);
  localparam int IMMW  = 16;
  localparam int TGTW  = 26;

  logic [DW-1:0]   pc_q, a_q, b_q, aluout_q, mdr_q, prod_q;
  logic [TGTW-1:0] ir_q;
  opclass_e        opclass_q;

  logic [DW-1:0] im_rdata, dm_rdata, rd1, rd2;
  logic [DW-1:0] src_a, src_b, alu_res, pc_next, imm_ext;

  logic    pc_jump, reg_dst, mem_to_reg, alu_src_a, use_funct, prod_write;
  logic    rd_wb, is_mul;
  srcb_e   alu_src_b;
  alu_op_e alu_op;

  mc_mem #(.AW(IM_AW), .DW(DW)) u_imem (
    .clk_i   (clk_i),
    .re_i    (1'b1),
    .we_i    (1'b0),
    .addr_i  (pc_q[IM_AW+1:2]),
    .wdata_i ('0),
    .rdata_o (im_rdata)
  );

  mc_mem #(.AW(DM_AW), .DW(DW)) u_dmem (
    .clk_i   (clk_i),
    .re_i    (mem_read_o),
    .we_i    (mem_write_o),
    .addr_i  (aluout_q[DM_AW+1:2]),
    .wdata_i (b_q),
    .rdata_o (dm_rdata)
  );

  mc_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .opclass_i    (opclass_q),
    .rd_wb_i      (rd_wb),
    .mul_i        (is_mul),
    .ir_write_o   (ir_write_o),
    .pc_write_o   (pc_write_o),
    .pc_jump_o    (pc_jump),
    .mem_read_o   (mem_read_o),
    .mem_write_o  (mem_write_o),
    .reg_write_o  (reg_write_o),
    .reg_dst_o    (reg_dst),
    .mem_to_reg_o (mem_to_reg),
    .alu_src_a_o  (alu_src_a),
    .alu_src_b_o  (alu_src_b),
    .use_funct_o  (use_funct),
    .prod_write_o (prod_write)
  );

  mc_alu_ctl u_aluctl (
    .en_i     (use_funct),
    .funct_i  (ir_q[5:0]),
    .alu_op_o (alu_op),
    .rd_wb_o  (rd_wb),
    .mul_o    (is_mul)
  );

  mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_write_o),
    .waddr_i  (rf_waddr_o),
    .wdata_i  (rf_wdata_o),
    .raddr1_i (ir_q[25:21]),
    .raddr2_i (ir_q[20:16]),
    .rdata1_o (rd1),
    .rdata2_o (rd2)
  );

  assign imm_ext = {{(DW-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
  assign src_a   = alu_src_a ? a_q : pc_q;

  always_comb begin
    case (alu_src_b)
      SB_FOUR: src_b = DW'(4);
      SB_IMM:  src_b = imm_ext;
      default: src_b = b_q;
    endcase
  end

  always_comb begin
    case (alu_op)
      AO_SUB:  alu_res = src_a - src_b;
      AO_MUL:  alu_res = src_a * src_b;
      AO_PROD: alu_res = prod_q;
      default: alu_res = src_a + src_b;
    endcase
  end

  assign pc_next = pc_jump ? {pc_q[DW-1:DW-4], ir_q, 2'b00} : alu_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      ir_q      <= '0;
      opclass_q <= OC_NONE;
      a_q       <= '0;
      b_q       <= '0;
      aluout_q  <= '0;
      mdr_q     <= '0;
      prod_q    <= '0;
    end else begin
      if (pc_write_o) pc_q <= pc_next;
      if (ir_write_o) begin
        ir_q      <= im_rdata[TGTW-1:0];
        opclass_q <= classify(im_rdata[DW-1:TGTW]);
      end
      a_q      <= rd1;
      b_q      <= rd2;
      aluout_q <= alu_res;
      mdr_q    <= dm_rdata;
      if (prod_write) prod_q <= alu_res;
    end
  end

  assign rf_waddr_o = reg_dst ? ir_q[15:11] : ir_q[20:16];
  assign rf_wdata_o = mem_to_reg ? mdr_q : aluout_q;
  assign pc_o       = pc_q;
  assign dm_addr_o  = aluout_q;
  assign dm_wdata_o = b_q;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] pc_o,
  input logic          ir_write_o,
  input logic          pc_write_o,
  input logic          mem_read_o,
  input logic          mem_write_o,
  input logic          reg_write_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_pc_r1: assert (pc_o == '0);
    end
  end

  p_strobe_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_read_o, mem_write_o, reg_write_o, ir_write_o}));

  p_fetch_pcw_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_write_o |-> pc_write_o);

  p_fetch_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_write_o |=> (pc_o == $past(pc_o) + DW'(4)));

  p_jump_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_o && !ir_write_o) |=>
      (ir_write_o && (pc_o[DW-1:DW-4] == $past(pc_o[DW-1:DW-4])) && (pc_o[1:0] == 2'b00)));

  p_store_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_write_o |=> ir_write_o);

  p_load_wb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_read_o |=> reg_write_o);

  p_pc_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_write_o |=> $stable(pc_o));

endmodule

bind mc_core mc_core_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_o        (pc_o),
  .ir_write_o  (ir_write_o),
  .pc_write_o  (pc_write_o),
  .mem_read_o  (mem_read_o),
  .mem_write_o (mem_write_o),
  .reg_write_o (reg_write_o)
);

// File: tb/mc_core_tb.sv
module mc_core_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NCYC  = 230;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [31:0] pc, rf_wd, dm_a, dm_wd;
  logic        irw, pcw, mr, mw, rw;
  logic [4:0]  rf_wa;

  mc_core u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pc_o        (pc),
    .ir_write_o  (irw),
    .pc_write_o  (pcw),
    .mem_read_o  (mr),
    .mem_write_o (mw),
    .reg_write_o (rw),
    .rf_waddr_o  (rf_wa),
    .rf_wdata_o  (rf_wd),
    .dm_addr_o   (dm_a),
    .dm_wdata_o  (dm_wd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [31:0] pc;
    logic        mr, mw, rw, irw, pcw;
    logic [4:0]  wa;
    logic [31:0] wd, da, dd;
    logic [7:0]  req;
  } exp_t;

  exp_t        eq[$];
  logic [31:0] m_im [DEPTH];
  logic [31:0] m_dm [DEPTH];
  logic [31:0] m_rf [32];
  logic [31:0] m_written;
  logic [31:0] m_prod, m_pc;

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_j(input int word);
    return {6'h02, 26'(word)};
  endfunction

  task automatic push(input logic [31:0] p, input logic r, input logic w, input logic g,
                      input logic i, input logic c, input logic [4:0] wa,
                      input logic [31:0] wd, input logic [31:0] da, input logic [31:0] dd,
                      input int req);
    exp_t e;
    e.pc = p; e.mr = r; e.mw = w; e.rw = g; e.irw = i; e.pcw = c;
    e.wa = wa; e.wd = wd; e.da = da; e.dd = dd; e.req = 8'(req);
    eq.push_back(e);
  endtask

  // behavioural reference: one instruction, one expected entry per clock
  task automatic model_step();
    logic [31:0] ins, npc, adr, val;
    logic [5:0]  op, fn;
    int          rs, rt, rd, tag;
    logic        wr;
    ins = m_im[m_pc[11:2]];
    op  = ins[31:26]; fn = ins[5:0];
    rs  = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    adr = m_rf[rs] + {{16{ins[15]}}, ins[15:0]};
    npc = m_pc + 32'd4;
    push(m_pc, 0, 0, 0, 1, 1, 0, 0, 0, 0, 2);                // R2 fetch
    case (op)
      6'h23: begin                                          // R3 load
        push(npc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11);
        push(npc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11);
        push(npc, 1, 0, 0, 0, 0, 0, 0, 0, 0, 3);
        val = m_dm[adr[11:2]];
        push(npc, 0, 0, 1, 0, 0, 5'(rt), val, 0, 0, 3);
        if (rt != 0) begin m_rf[rt] = val; m_written[rt] = 1'b1; end
      end
      6'h2B: begin                                          // R4 store
        push(npc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11);
        push(npc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11);
        tag = (rt == 0) ? 9 : (m_written[rt] ? 4 : 1);
        push(npc, 0, 1, 0, 0, 0, 0, 0, adr, m_rf[rt], tag);
        m_dm[adr[11:2]] = m_rf[rt];
      end
      6'h00: begin                                          // R5 R6 R7 R10
        push(npc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11);
        push(npc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11);
        wr = 1'b1; val = 32'd0;
        case (fn)
          6'h20: begin val = m_rf[rs] + m_rf[rt]; tag = 5; end
          6'h22: begin val = m_rf[rs] - m_rf[rt]; tag = 5; end
          6'h18: begin m_prod = m_rf[rs] * m_rf[rt]; wr = 1'b0; tag = 6; end
          6'h12: begin val = m_prod; tag = 7; end
          default: begin wr = 1'b0; tag = 10; end
        endcase
        if (wr && rd == 0) tag = 9;
        push(npc, 0, 0, wr, 0, 0, 5'(rd), val, 0, 0, tag);
        if (wr && rd != 0) begin m_rf[rd] = val; m_written[rd] = 1'b1; end
      end
      6'h02: begin                                          // R8 jump
        push(npc, 0, 0, 0, 0, 1, 0, 0, 0, 0, 8);
        npc = {npc[31:28], ins[25:0], 2'b00};
      end
      default: push(npc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 10);    // R10 unknown opcode
    endcase
    m_pc = npc;
  endtask

  task automatic check_cycle(input int cyc);
    exp_t e;
    logic bad;
    e = eq.pop_front();
    bad = (pc !== e.pc) || (mr !== e.mr) || (mw !== e.mw) || (rw !== e.rw) ||
          (irw !== e.irw) || (pcw !== e.pcw);
    if (e.rw) bad = bad || (rf_wa !== e.wa) || (rf_wd !== e.wd);
    if (e.mw) bad = bad || (dm_a !== e.da) || (dm_wd !== e.dd);
    n_cmp++;
    if (bad) begin
      n_bad++;
      $display("FAIL R%0d cycle %0d (got/exp): pc %h/%h mr %b/%b mw %b/%b rw %b/%b irw %b/%b pcw %b/%b wa %0d/%0d wd %h/%h da %h/%h dd %h/%h",
               e.req, cyc, pc, e.pc, mr, e.mr, mw, e.mw, rw, e.rw, irw, e.irw, pcw, e.pcw,
               rf_wa, e.wa, rf_wd, e.wd, dm_a, e.da, dm_wd, e.dd);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      m_im[i] = 32'd0;
      m_dm[i] = 32'd0;
    end
    m_im[0]  = 32'h8F890064;                     // R3 lw r9, 0x64(r28)
    m_im[1]  = 32'hAF890060;                     // R4 sw r9, 0x60(r28)
    m_im[2]  = enc_i(6'h2B, 0, 7, 16'h0068);     // R1 unwritten r7 stores zero
    m_im[3]  = enc_i(6'h23, 0, 10, 16'h0070);
    m_im[4]  = enc_i(6'h23, 0, 11, 16'h0074);
    m_im[5]  = enc_r(9, 11, 12, 6'h20);          // R5 add
    m_im[6]  = enc_r(11, 10, 13, 6'h22);         // R5 sub of negative
    m_im[7]  = enc_r(0, 11, 14, 6'h22);          // R5 wrap below zero
    m_im[8]  = enc_r(10, 11, 0, 6'h18);          // R6 multiply
    m_im[9]  = enc_r(12, 12, 15, 6'h20);
    m_im[10] = enc_i(6'h23, 17, 16, 16'hFFFC);   // R3 negative offset wraps
    m_im[11] = enc_r(0, 0, 18, 6'h12);           // R7 move product
    m_im[12] = enc_r(9, 9, 0, 6'h20);            // R9 write to r0
    m_im[13] = enc_i(6'h2B, 0, 0, 16'h0078);     // R9 r0 still zero
    m_im[14] = enc_r(0, 9, 19, 6'h20);           // R9 r0 reads zero
    m_im[15] = 32'hFC000000;                     // R10 unknown opcode
    m_im[16] = enc_r(9, 9, 20, 6'h3F);           // R10 unknown funct
    m_im[17] = enc_i(6'h2B, 0, 20, 16'h007C);    // R10 r20 untouched
    m_im[18] = enc_i(6'h23, 0, 21, 16'h0060);    // R4 load back stored word
    m_im[19] = enc_j(25);                        // R8 jump
    for (int i = 20; i < 25; i++) m_im[i] = enc_i(6'h2B, 0, 9, 16'h0080);
    m_im[25] = enc_r(0, 0, 22, 6'h12);           // R6 product held across jump
    m_im[26] = enc_j(26);
    m_dm[25]  = 32'h30303030;
    m_dm[28]  = 32'hFFFFFFF0;
    m_dm[29]  = 32'h00000007;
    m_dm[1023] = 32'hCAFEF00D;
    for (int i = 0; i < DEPTH; i++) begin
      u_dut.u_imem.mem_q[i] = m_im[i];
      u_dut.u_dmem.mem_q[i] = m_dm[i];
    end
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    m_written = 32'd0;
    m_prod    = 32'd0;
    m_pc      = 32'd0;
    while (eq.size() < NCYC) model_step();

    repeat (3) @(posedge clk);
    #1;
    // R1 reset state: pc zero, fetch strobes only
    n_cmp++;
    if (pc !== 32'd0 || irw !== 1'b1 || pcw !== 1'b1 || mr !== 1'b0 || mw !== 1'b0 || rw !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset (got/exp): pc %h/0 irw %b/1 pcw %b/1 mr %b/0 mw %b/0 rw %b/0",
               pc, irw, pcw, mr, mw, rw);
    end
    #0.5 rst_n = 1'b1;
    #0.1 check_cycle(0);
    for (int c = 1; c < NCYC; c++) begin
      @(posedge clk);
      #1 check_cycle(c);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired (got/exp): running/finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule